// File: doc/BRIEF.md
# Compressed Bitstream Serial Receiver with Throttle

This block accepts a compressed audio bitstream from a host over three wires: a serial bit clock, a frame sync and a data line. All three inputs are brought into the system clock domain through a two-flop synchronizer. A control input picks which transition of the bit clock is the sampling edge, and that edge is detected on the synchronized copy of the bit clock. Each sampled bit is shifted in with the most significant bit first. A sync bit marks the first bit of a new byte.

Each completed byte is written into a 16-entry FIFO. The FIFO shows its oldest byte at its output, and the decoding core removes that byte with a read strobe. The throttle output tells the host when to pause. It goes high when the FIFO is close to full and goes low again only after the FIFO has drained well down. A byte that arrives while the FIFO is full is discarded, and a sticky overflow flag records the loss.

Top module: `bsrx_top`

## Requirements
- R1: After reset, rd_valid, throttle and overflow are all 0.
- R2: With edge_sel = 1, ser_data is sampled on the rising edge of ser_clk. With edge_sel = 0, it is sampled on the falling edge. The other edge has no effect on the data.
- R3: Bits form bytes with the most significant bit first. The first bit sampled becomes bit 7.
- R4: A bit sampled while ser_sync is high becomes bit 7 of a new byte, and any partly assembled byte is thrown away.
- R5: Bytes leave the FIFO in arrival order. rd_data shows the oldest byte whenever rd_valid is 1, and a cycle with rd_en high removes that byte.
- R6: The FIFO holds 16 bytes. A byte that completes while 16 bytes are stored is dropped, even if a read happens in the same cycle, and the stored bytes stay unchanged.
- R7: A dropped byte sets overflow, and overflow stays at 1 until reset.
- R8: throttle rises in the same cycle that the occupancy reaches 12.
- R9: Once throttle is high, it stays high until the occupancy falls to 4, and then it drops. Between 5 and 11 bytes it keeps its previous value.
- R10: rd_en while the FIFO is empty is ignored. rd_valid stays 0 and the next byte is read out correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| edge_sel | input | 1 | Sampling edge select: 1 = rising, 0 = falling |
| ser_clk | input | 1 | Serial bit clock from the host (asynchronous) |
| ser_sync | input | 1 | Frame sync; high marks the first bit of a byte |
| ser_data | input | 1 | Serial data, MSB first |
| rd_en | input | 1 | Read strobe from the decoding core |
| rd_data | output | 8 | Oldest stored byte |
| rd_valid | output | 1 | FIFO holds at least one byte |
| throttle | output | 1 | 1 = host must pause, 0 = host may send |
| overflow | output | 1 | Sticky flag: a byte was dropped |

## Verification
The bench changes the data line to a deliberately wrong value halfway between the two clock edges. A design that samples on the wrong edge would therefore load the complemented bits and return inverted bytes. Junk bits and truncated bytes are sent before a synced byte, so a design that does not realign on sync would return shifted data. The bench fills the FIFO exactly to 16 and then adds one more byte. A design that dropped the byte too early, or overwrote a stored byte, would return the wrong read-out sequence or a wrong count. Throttle is checked at 11, 12, 5 and 4 bytes, which catches both an off-by-one threshold and a design without hysteresis that releases at the first read.

// File: rtl/bsrx_pkg.sv
package bsrx_pkg;

  // Next throttle state from the current state and the updated occupancy.
  function automatic logic thr_next(input logic cur, input int unsigned lvl,
                                    input int unsigned hi, input int unsigned lo);
    if (lvl >= hi) return 1'b1;
    if (lvl <= lo) return 1'b0;
    return cur;
  endfunction

  // Circular pointer advance for an arbitrary depth.
  function automatic int unsigned ptr_adv(input int unsigned p, input int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/bsrx_sync_edge.sv
module bsrx_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_sel,
  input  logic ser_clk,
  input  logic ser_sync,
  input  logic ser_data,
  output logic sample,
  output logic smp_sync,
  output logic smp_data
);
  logic [2:0] pipe [STAGES];
  logic       clk_prev;
  logic       clk_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
      clk_prev <= 1'b0;
    end else begin
      pipe[0] <= {ser_clk, ser_sync, ser_data};
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      clk_prev <= pipe[STAGES-1][2];
    end
  end

  assign clk_s    = pipe[STAGES-1][2];
  assign smp_sync = pipe[STAGES-1][1];
  assign smp_data = pipe[STAGES-1][0];
  assign sample   = edge_sel ? (clk_s & ~clk_prev) : (~clk_s & clk_prev);

  // An edge lasts a single system cycle.
  AST_SAMPLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sample |=> !sample); // R2

endmodule

// File: rtl/bsrx_shifter.sv
module bsrx_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample,
  input  logic              smp_sync,
  input  logic              smp_data,
  output logic              byte_stb,
  output logic [DATA_W-1:0] byte_out
);
  localparam int CNT_W = $clog2(DATA_W);

  logic [DATA_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg    <= '0;
      cnt      <= '0;
      byte_stb <= 1'b0;
      byte_out <= '0;
    end else begin
      byte_stb <= 1'b0;
      if (sample) begin
        if (smp_sync) begin
          shreg <= {{(DATA_W-1){1'b0}}, smp_data};
          cnt   <= CNT_W'(1);
        end else if (cnt == CNT_W'(DATA_W-1)) begin
          byte_out <= {shreg[DATA_W-2:0], smp_data};
          byte_stb <= 1'b1;
          cnt      <= '0;
        end else begin
          shreg <= {shreg[DATA_W-2:0], smp_data};
          cnt   <= CNT_W'(cnt + 1'b1);
        end
      end
    end
  end

  AST_STB_FROM_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb |-> $past(sample) && !$past(smp_sync)); // R4

endmodule

// File: rtl/bsrx_fifo.sv
module bsrx_fifo
  import bsrx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int THR_HI = 12,
  parameter int THR_LO = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              throttle,
  output logic              overflow
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wptr, rptr;
  logic [LVL_W-1:0]  count, count_nx;
  logic              full, push, pop, drop;

  assign full     = (count == LVL_W'(DEPTH));
  assign push     = wr_stb && !full;
  assign drop     = wr_stb && full;
  assign pop      = rd_en && (count != '0);
  assign count_nx = LVL_W'(count + LVL_W'(push) - LVL_W'(pop));
  assign rd_valid = (count != '0);
  assign rd_data  = mem[rptr];

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wr_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr     <= '0;
      rptr     <= '0;
      count    <= '0;
      throttle <= 1'b0;
      overflow <= 1'b0;
    end else begin
      if (push) wptr <= PTR_W'(ptr_adv(int'(wptr), DEPTH));
      if (pop)  rptr <= PTR_W'(ptr_adv(int'(rptr), DEPTH));
      count    <= count_nx;
      throttle <= thr_next(throttle, int'(count_nx), THR_HI, THR_LO);
      if (drop) overflow <= 1'b1;
    end
  end

  AST_NO_OVERFILL: assert property (@(posedge clk) disable iff (!rst_n)
    count <= LVL_W'(DEPTH)); // R6
  AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && full) |=> overflow); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow); // R7
  AST_THR_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(throttle) |-> count >= LVL_W'(THR_HI)); // R8
  AST_THR_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(throttle) |-> count <= LVL_W'(THR_LO)); // R9
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_valid && !wr_stb) |=> !rd_valid); // R10

endmodule

// File: rtl/bsrx_top.sv
module bsrx_top #(
  parameter int DATA_W      = 8,
  parameter int DEPTH       = 16,
  parameter int THR_HI      = 12,
  parameter int THR_LO      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              edge_sel,
  input  logic              ser_clk,
  input  logic              ser_sync,
  input  logic              ser_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              throttle,
  output logic              overflow
);
  logic              sample, smp_sync, smp_data;
  logic              byte_stb;
  logic [DATA_W-1:0] byte_val;

  bsrx_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .edge_sel(edge_sel),
    .ser_clk(ser_clk), .ser_sync(ser_sync), .ser_data(ser_data),
    .sample(sample), .smp_sync(smp_sync), .smp_data(smp_data)
  );

  bsrx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .sample(sample), .smp_sync(smp_sync),
    .smp_data(smp_data), .byte_stb(byte_stb), .byte_out(byte_val)
  );

  bsrx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .THR_HI(THR_HI), .THR_LO(THR_LO)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_stb(byte_stb), .wr_byte(byte_val),
    .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
    .throttle(throttle), .overflow(overflow)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!rd_valid && !throttle && !overflow)); // R1

endmodule

// File: tb/bsrx_top_test.sv
module bsrx_top_test;
  localparam int H = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       edge_sel = 1'b1;
  logic       ser_clk = 1'b0;
  logic       ser_sync = 1'b0;
  logic       ser_data = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       rd_valid, throttle, overflow;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bsrx_top uut (
    .clk(clk), .rst_n(rst_n), .edge_sel(edge_sel), .ser_clk(ser_clk),
    .ser_sync(ser_sync), .ser_data(ser_data), .rd_en(rd_en),
    .rd_data(rd_data), .rd_valid(rd_valid), .throttle(throttle), .overflow(overflow)
  );

  // {edge_sel, byte}
  localparam logic [8:0] VEC [8] = '{
    {1'b1, 8'hA5}, {1'b1, 8'h3C}, {1'b0, 8'h81}, {1'b0, 8'h7E},
    {1'b1, 8'h00}, {1'b0, 8'hFF}, {1'b1, 8'h96}, {1'b0, 8'h1D}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; rd_en = 1'b0; ser_sync = 1'b0;
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(2);
  endtask

  task automatic set_mode(input logic m);
    @(negedge clk);
    edge_sel = m;
    ser_clk  = m ? 1'b0 : 1'b1;
    wait_cyc(6);
  endtask

  // Data turns to its complement between the edges: wrong-edge sampling sees it.
  task automatic send_bit(input logic d, input logic s);
    logic act;
    act = edge_sel;
    ser_data = d; ser_sync = s;
    wait_cyc(H);
    ser_clk = act;
    wait_cyc(H);
    ser_data = ~d; ser_sync = 1'b0;
    wait_cyc(H);
    ser_clk = ~act;
    wait_cyc(H);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i], i == 7);
    wait_cyc(4);
  endtask

  task automatic pop_check(input logic [7:0] exp, input string req);
    check(rd_valid === 1'b1, req, rd_valid, 1);
    check(rd_data === exp, req, rd_data, exp);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    check(rd_valid === 1'b0, "R1 rd_valid", rd_valid, 0);
    check(throttle === 1'b0, "R1 throttle", throttle, 0);
    check(overflow === 1'b0, "R1 overflow", overflow, 0);

    // R10 read of empty FIFO ignored
    rd_en = 1'b1; wait_cyc(3); rd_en = 1'b0;
    check(rd_valid === 1'b0, "R10 empty read", rd_valid, 0);
    send_byte(8'hC3);
    pop_check(8'hC3, "R10 after empty read");
    check(rd_valid === 1'b0, "R10 drained", rd_valid, 0);

    // R2 R3 table of edges and bytes
    for (int k = 0; k < 8; k++) begin
      if (VEC[k][8] !== edge_sel) set_mode(VEC[k][8]);
      send_byte(VEC[k][7:0]);
      pop_check(VEC[k][7:0], VEC[k][8] ? "R2 R3 rising" : "R2 R3 falling");
    end

    // R4 realignment after junk and a truncated byte
    set_mode(1'b1);
    send_bit(1'b1, 1'b0); send_bit(1'b0, 1'b0); send_bit(1'b1, 1'b0);
    send_byte(8'h5A);
    pop_check(8'h5A, "R4 junk before sync");
    for (int i = 0; i < 5; i++) send_bit(1'b1, i == 0);
    send_byte(8'h24);
    pop_check(8'h24, "R4 truncated byte");
    check(rd_valid === 1'b0, "R4 no extra byte", rd_valid, 0);

    // R8 R9 throttle thresholds and hysteresis
    do_reset();
    for (int i = 0; i < 11; i++) send_byte(8'(8'h10 + i));
    check(throttle === 1'b0, "R8 at 11", throttle, 0);
    send_byte(8'h1B);
    check(throttle === 1'b1, "R8 at 12", throttle, 1);
    for (int i = 0; i < 7; i++) pop_check(8'(8'h10 + i), "R5 order");
    check(throttle === 1'b1, "R9 held at 5", throttle, 1);
    pop_check(8'h17, "R5 order");
    check(throttle === 1'b0, "R9 release at 4", throttle, 0);
    for (int i = 0; i < 4; i++) pop_check(8'(8'h18 + i), "R5 order");

    // R6 R7 overflow
    do_reset();
    for (int i = 0; i < 16; i++) send_byte(8'(8'h40 + i));
    check(overflow === 1'b0, "R6 full no overflow", overflow, 0);
    send_byte(8'hEE);
    check(overflow === 1'b1, "R7 overflow set", overflow, 1);
    for (int i = 0; i < 16; i++) pop_check(8'(8'h40 + i), "R6 contents");
    check(rd_valid === 1'b0, "R6 dropped byte absent", rd_valid, 0);
    check(overflow === 1'b1, "R7 sticky", overflow, 1);
    do_reset();
    check(overflow === 1'b0, "R7 cleared by reset", overflow, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule